// File: doc/BRIEF.md
# Power-Scheme Oversampling Averager

This block takes a stream of signed raw conversions and turns every window of them into one averaged result. The window length is the oversampling ratio. A two-dimensional table picks it from the active power scheme and a two-bit output-rate code. Two schemes are stored in a control register, one for the awake state and one for the asleep state. An auto-sleep enable and a sleep status input decide which of the two is in force.

The control register also holds a self-test enable and a write-one software reset. Self-test adds a fixed offset to every conversion before it is summed. The software reset returns both registers to zero at once. The rate code sits in a second register. Every ratio is a power of two, so the average is the running sum shifted right arithmetically. The result is clipped to the signed sample range and appears with a one-cycle strobe.

Top module: `osa_avg_top`

## Requirements
- R1: The control register is at address 0 and resets to 0x00. Its fields are: bit 7 self-test enable, bits 4:3 sleep scheme, bit 2 auto-sleep enable, bits 1:0 wake scheme. Bit 6 (reset) and bit 5 (reserved) always read 0.
- R2: The rate register is at address 1, bits 1:0, and resets to 0. Codes 0/1/2/3 select the slowest to the fastest rate. Bits 7:2 read 0.
- R3: A write to address 0 with bit 6 set clears both registers on that clock edge, whatever the other written bits are. It also discards any partly collected window.
- R4: Scheme codes are 0 Normal, 1 Low-Noise Low-Power, 2 High-Resolution and 3 Low-Power. For rate codes 0/1/2/3 the ratios are: Normal 128/32/16/4, Low-Noise Low-Power 32/8/4/4, High-Resolution 1024/256/128/32, Low-Power 16/4/2/2.
- R5: The sleep scheme applies when auto-sleep is enabled and `asleep_i` is high. In every other case the wake scheme applies.
- R6: The output equals floor(sum of the window's samples / ratio), clipped to the range -512..511.
- R7: While self-test is enabled, each accepted sample is raised by ST_OFS (default 100) before it is summed.
- R8: `avg_vld` is high for exactly one cycle, in the cycle that follows the clock edge accepting the last sample of a window. It never rises before a full window has been collected. Cycles with `smp_vld` low are not counted.
- R9: A change of ratio, self-test state or active scheme in the middle of a window discards the partial sum. A new window then starts under the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 rate |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| asleep_i | input | 1 | Sleep status from the system |
| smp_vld | input | 1 | Raw sample strobe |
| smp_data | input | DW | Signed raw sample |
| avg_vld | output | 1 | One-cycle result strobe |
| avg_data | output | DW | Signed averaged result |

## Verification
The hardest situations to reach are a window that has been partly filled when the settings move under it, and a software reset that arrives while the configuration is still at its defaults. In that second case no change of settings reveals the flush. The stimulus fills a few samples of a short window and then stretches the ratio. The bench then checks that no strobe comes where the stale count would have finished. It also issues a reset on top of the default configuration after several large samples, and then checks that the next result reflects only the new samples.

// File: rtl/osa_pkg.sv
package osa_pkg;

    localparam int MAX_SHIFT   = 10;
    localparam int CTRL_RST_BIT = 6;

    typedef enum logic [1:0] {
        SCH_NORMAL = 2'd0,
        SCH_LNLP   = 2'd1,
        SCH_HIRES  = 2'd2,
        SCH_LOWPWR = 2'd3
    } scheme_e;

    typedef enum logic [1:0] {
        RATE_SLOWEST = 2'd0,
        RATE_SLOW    = 2'd1,
        RATE_FAST    = 2'd2,
        RATE_FASTEST = 2'd3
    } rate_e;

    typedef struct packed {
        logic    selftest;
        scheme_e slp_sch;
        logic    asleep_en;
        scheme_e wake_sch;
    } ctrl_t;

    typedef struct packed {
        logic [3:0] shift;
        logic       selftest;
    } win_cfg_t;

    // log2 of the oversampling ratio for a scheme and rate
    function automatic logic [3:0] os_shift(scheme_e sch, rate_e rate);
        logic [3:0] s;
        unique case (sch)
            SCH_NORMAL: begin
                unique case (rate)
                    RATE_SLOWEST: s = 4'd7;
                    RATE_SLOW:    s = 4'd5;
                    RATE_FAST:    s = 4'd4;
                    default:      s = 4'd2;
                endcase
            end
            SCH_LNLP: begin
                unique case (rate)
                    RATE_SLOWEST: s = 4'd5;
                    RATE_SLOW:    s = 4'd3;
                    default:      s = 4'd2;
                endcase
            end
            SCH_HIRES: begin
                unique case (rate)
                    RATE_SLOWEST: s = 4'd10;
                    RATE_SLOW:    s = 4'd8;
                    RATE_FAST:    s = 4'd7;
                    default:      s = 4'd5;
                endcase
            end
            default: begin
                unique case (rate)
                    RATE_SLOWEST: s = 4'd4;
                    RATE_SLOW:    s = 4'd2;
                    default:      s = 4'd1;
                endcase
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/osa_regs.sv
module osa_regs
    import osa_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output ctrl_t       ctrl_o,
    output rate_e       rate_o,
    output logic        srst_o
);

    ctrl_t ctrl_q;
    rate_e rate_q;

    assign srst_o = reg_wr && !reg_addr && reg_wdata[CTRL_RST_BIT];

    always_ff @(posedge clk) begin
        if (rst || srst_o) begin
            ctrl_q <= '0;
            rate_q <= RATE_SLOWEST;
        end else if (reg_wr) begin
            if (!reg_addr) begin
                ctrl_q <= ctrl_t'({reg_wdata[7], reg_wdata[4:0]});
            end else begin
                rate_q <= rate_e'(reg_wdata[1:0]);
            end
        end
    end

    always_comb begin
        if (!reg_addr) begin
            reg_rdata = {ctrl_q.selftest, 2'b00, ctrl_q.slp_sch,
                         ctrl_q.asleep_en, ctrl_q.wake_sch};
        end else begin
            reg_rdata = {6'b0, rate_q};
        end
    end

    assign ctrl_o = ctrl_q;
    assign rate_o = rate_q;

    // R3
    swrst_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr && reg_wdata[CTRL_RST_BIT]) |=> (ctrl_o == '0 && rate_o == RATE_SLOWEST));

    // R2
    rate_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr) |=> (rate_o == rate_e'($past(reg_wdata[1:0]))));

endmodule

// File: rtl/osa_sel.sv
module osa_sel
    import osa_pkg::*;
(
    input  ctrl_t    ctrl_i,
    input  rate_e    rate_i,
    input  logic     asleep_i,
    output win_cfg_t cfg_o
);

    scheme_e active_sch;

    always_comb begin
        active_sch     = (ctrl_i.asleep_en && asleep_i) ? ctrl_i.slp_sch : ctrl_i.wake_sch;
        cfg_o.shift    = os_shift(active_sch, rate_i);
        cfg_o.selftest = ctrl_i.selftest;
    end

endmodule

// File: rtl/osa_accum.sv
module osa_accum
    import osa_pkg::*;
#(
    parameter int DW     = 10,
    parameter int ST_OFS = 100
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush_i,
    input  win_cfg_t             cfg_i,
    input  logic                 smp_vld,
    input  logic signed [DW-1:0] smp_data,
    output logic                 avg_vld,
    output logic signed [DW-1:0] avg_data
);

    localparam int ACC_W = DW + MAX_SHIFT + 2;
    localparam int CNT_W = MAX_SHIFT + 1;
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (DW - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

    win_cfg_t                 cfg_q;
    logic [CNT_W-1:0]         cnt_q, base_cnt, last_idx;
    logic signed [ACC_W-1:0]  acc_q, base_acc, smp_ext, sum, shifted;
    logic signed [DW-1:0]     clipped;
    logic                     restart, last;

    always_comb begin
        restart  = flush_i || (cfg_i != cfg_q);
        base_acc = restart ? '0 : acc_q;
        base_cnt = restart ? '0 : cnt_q;
        smp_ext  = {{(ACC_W - DW){smp_data[DW-1]}}, smp_data};
        if (cfg_i.selftest) begin
            smp_ext = smp_ext + ACC_W'(ST_OFS);
        end
        sum      = base_acc + smp_ext;
        last_idx = CNT_W'((1 << cfg_i.shift) - 1);
        last     = smp_vld && (base_cnt == last_idx);
        shifted  = sum >>> cfg_i.shift;
        if (shifted > MAXV) begin
            clipped = MAXV[DW-1:0];
        end else if (shifted < MINV) begin
            clipped = MINV[DW-1:0];
        end else begin
            clipped = shifted[DW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            cnt_q    <= '0;
            acc_q    <= '0;
            avg_vld  <= 1'b0;
            avg_data <= '0;
        end else begin
            cfg_q   <= cfg_i;
            avg_vld <= 1'b0;
            if (last) begin
                acc_q    <= '0;
                cnt_q    <= '0;
                avg_vld  <= 1'b1;
                avg_data <= clipped;
            end else if (smp_vld) begin
                acc_q <= sum;
                cnt_q <= base_cnt + CNT_W'(1);
            end else begin
                acc_q <= base_acc;
                cnt_q <= base_cnt;
            end
        end
    end

    // R8
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        avg_vld |=> !avg_vld);

    // R8
    vld_after_smp_chk: assert property (@(posedge clk) disable iff (rst)
        avg_vld |-> $past(smp_vld));

    // R9
    restart_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        ((cfg_i != cfg_q) && !smp_vld) |=> (cnt_q == '0));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(cnt_q) < (32'd1 << cfg_q.shift)));

endmodule

// File: rtl/osa_avg_top.sv
module osa_avg_top
    import osa_pkg::*;
#(
    parameter int DW     = 10,
    parameter int ST_OFS = 100
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic                 reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic                 asleep_i,
    input  logic                 smp_vld,
    input  logic signed [DW-1:0] smp_data,
    output logic                 avg_vld,
    output logic signed [DW-1:0] avg_data
);

    ctrl_t    ctrl;
    rate_e    rate;
    logic     srst;
    win_cfg_t cfg;

    osa_regs regs_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctrl_o    (ctrl),
        .rate_o    (rate),
        .srst_o    (srst)
    );

    osa_sel sel_i (
        .ctrl_i   (ctrl),
        .rate_i   (rate),
        .asleep_i (asleep_i),
        .cfg_o    (cfg)
    );

    osa_accum #(
        .DW     (DW),
        .ST_OFS (ST_OFS)
    ) accum_i (
        .clk      (clk),
        .rst      (rst),
        .flush_i  (srst),
        .cfg_i    (cfg),
        .smp_vld  (smp_vld),
        .smp_data (smp_data),
        .avg_vld  (avg_vld),
        .avg_data (avg_data)
    );

endmodule

// File: tb/osa_avg_top_tb_top.sv
`timescale 1ns/1ps
module osa_avg_top_tb_top;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic             reg_addr = 1'b0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic             asleep_i = 1'b0;
    logic             smp_vld = 1'b0;
    logic signed [9:0] smp_data = '0;
    logic             avg_vld;
    logic signed [9:0] avg_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    osa_avg_top dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .asleep_i(asleep_i),
        .smp_vld(smp_vld), .smp_data(smp_data), .avg_vld(avg_vld), .avg_data(avg_data)
    );

    typedef struct packed {
        logic [7:0]        ctrl;
        logic [1:0]        rate;
        logic              asleep;
        logic signed [9:0] a;
        logic signed [9:0] b;
        logic signed [9:0] expv;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 2'd3, 1'b0,   10'sd10,   10'sd20,   10'sd15},   // R4 R6
        '{8'h00, 2'd0, 1'b0,   -10'sd7,   -10'sd8,   -10'sd8},   // R6 floor
        '{8'h01, 2'd1, 1'b0,  10'sd100,  -10'sd50,   10'sd25},   // R4
        '{8'h02, 2'd0, 1'b0,    10'sd3,    10'sd4,    10'sd3},   // R4 deepest
        '{8'h03, 2'd2, 1'b0,  10'sd511,  10'sd510,  10'sd510},   // R4
        '{8'h17, 2'd3, 1'b1, -10'sd512, -10'sd512, -10'sd512},   // R5 sleep
        '{8'h17, 2'd3, 1'b0,    10'sd5,    10'sd6,    10'sd5},   // R5 awake
        '{8'h10, 2'd1, 1'b1,    10'sd1,    10'sd2,    10'sd1},   // R5 no auto-sleep
        '{8'h80, 2'd3, 1'b0,  10'sd500,  10'sd500,  10'sd511},   // R7 R6 clip
        '{8'h81, 2'd2, 1'b0,  -10'sd20,  -10'sd10,   10'sd85},   // R7
        '{8'h02, 2'd2, 1'b0,   -10'sd1,    10'sd0,   -10'sd1},   // R6
        '{8'h01, 2'd0, 1'b0,    10'sd7,    10'sd9,    10'sd8}    // R4
    };

    function automatic int bench_ratio(logic [7:0] c, logic [1:0] r, logic slp);
        logic [1:0] s;
        s = (c[2] && slp) ? c[4:3] : c[1:0];
        case ({s, r})
            4'b0000: return 128;  4'b0001: return 32;   4'b0010: return 16;  4'b0011: return 4;
            4'b0100: return 32;   4'b0101: return 8;    4'b0110: return 4;   4'b0111: return 4;
            4'b1000: return 1024; 4'b1001: return 256;  4'b1010: return 128; 4'b1011: return 32;
            4'b1100: return 16;   4'b1101: return 4;    4'b1110: return 2;   default: return 2;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic a, input logic [7:0] expv, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == expv, tag, int'(reg_rdata), int'(expv));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // feeds n samples alternating a/b; returns strobe and data seen after the last one
    task automatic feed(input int n, input int a, input int b, input bit gaps,
                        output bit early, output bit got, output int val);
        early = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (avg_vld) early = 1'b1;
            if (gaps && (i % 3 == 1)) begin
                smp_vld = 1'b0;
                @(negedge clk);
                if (avg_vld) early = 1'b1;
            end
            smp_vld  = 1'b1;
            smp_data = 10'((i % 2 == 0) ? a : b);
        end
        @(negedge clk);
        smp_vld = 1'b0;
        got = avg_vld;
        val = int'(avg_data);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit e, g;
        int v;
        idle(3);
        @(negedge clk);
        rst = 1'b0;

        // reset state
        rd_chk(1'b0, 8'h00, "R1 ctrl reset");
        rd_chk(1'b1, 8'h00, "R2 rate reset");
        chk(avg_vld == 1'b0, "R8 no strobe after reset", int'(avg_vld), 0);

        // vector table
        for (int k = 0; k < NV; k++) begin
            wr(1'b0, VECS[k].ctrl);
            wr(1'b1, {6'b0, VECS[k].rate});
            asleep_i = VECS[k].asleep;
            idle(2);
            feed(bench_ratio(VECS[k].ctrl, VECS[k].rate, VECS[k].asleep),
                 int'(VECS[k].a), int'(VECS[k].b), (k % 4 == 3), e, g, v);
            chk(!e, $sformatf("R8 early strobe vec %0d", k), int'(e), 0);
            chk(g, $sformatf("R8 strobe vec %0d", k), int'(g), 1);
            chk(v == int'(VECS[k].expv), $sformatf("R6 value vec %0d", k), v, int'(VECS[k].expv));
            @(negedge clk);
            chk(!avg_vld, $sformatf("R8 single cycle vec %0d", k), int'(avg_vld), 0);
        end
        asleep_i = 1'b0;

        // register fields, reserved bit and reset bit
        wr(1'b0, 8'hBF);
        rd_chk(1'b0, 8'h9F, "R1 rsvd reads zero");
        wr(1'b1, 8'hFE);
        rd_chk(1'b1, 8'h02, "R2 rate upper zero");
        wr(1'b0, 8'h7F);
        rd_chk(1'b0, 8'h00, "R3 reset clears ctrl");
        rd_chk(1'b1, 8'h00, "R3 reset clears rate");
        wr(1'b0, 8'h05);
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h40);
        rd_chk(1'b0, 8'h00, "R3 plain reset ctrl");
        rd_chk(1'b1, 8'h00, "R3 plain reset rate");

        // R9 mid-window change discards partial
        wr(1'b1, 8'h03);              // Normal, ratio 4
        idle(2);
        feed(2, 300, 300, 1'b0, e, g, v);
        wr(1'b1, 8'h02);              // Normal, ratio 16
        idle(1);
        feed(2, 8, 8, 1'b0, e, g, v);
        chk(!g && !e, "R9 no stale completion", int'(g), 0);
        feed(14, 8, 8, 1'b0, e, g, v);
        chk(g && v == 8, "R9 fresh window value", v, 8);

        // R3 reset on default config flushes partial
        wr(1'b1, 8'h00);              // ratio 128
        idle(2);
        feed(5, 400, 400, 1'b0, e, g, v);
        wr(1'b0, 8'h40);
        idle(1);
        feed(128, -4, -4, 1'b0, e, g, v);
        chk(!e && g, "R3 strobe after flush", int'(g), 1);
        chk(v == -4, "R3 flushed value", v, -4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule